// File: doc/BRIEF.md
# Preamble Edge-Interval Bit Checker

This block decides whether a demodulated serial line carries a genuine preamble before a receiver commits to decoding it. A slow timing-clock enable drives an interval counter. The block compares that count against a programmed window each time the line changes level. After an enable and a start-up period, the block waits for the first transition. It then requires a selectable number of consecutive transition-to-transition intervals to land inside the window.

A full run of good intervals gives a one-cycle pass pulse, which the surrounding receiver uses to enter receiving mode. Any interval that is too short gives an immediate one-cycle fail pulse. So does a count that reaches the upper limit with no transition. Either outcome returns the block to idle. It stays there until the enable is dropped and raised again, or until a restart strobe arrives while the enable is high.

Top module: `preamble_check`

## Requirements
- R1: After reset, `pass`, `fail` and `busy` are low.
- R2: A check begins, and `busy` goes high, on the first clock with `en` high after a clock where it was low, or on any clock where `restart` and `en` are both high. Line transitions before `startup_done` is seen high have no effect on the outcome.
- R3: The first line transition after start-up completes only starts interval timing and is never judged against the limits.
- R4: The interval count advances once per `tick` while measuring. It restarts at zero on each transition, and a tick in that same cycle is not counted. An interval is good when its count at the transition is at least `lim_lo` and below `lim_hi`. With `tick` held high, a transition spacing of P clocks yields a count of P-1.
- R5: A transition whose interval count is below `lim_lo` ends the check with a fail pulse.
- R6: When the interval count reaches `lim_hi`, the check fails on the next clock without waiting for a transition. The count never rises above `lim_hi`.
- R7: `run_sel` selects the run length: 0 needs 3 good intervals, 1 needs 6, and 2 or 3 need 9. The pass pulse comes right after the last good interval of the run.
- R8: `pass` and `fail` are single-cycle pulses that are never high together. `busy` is low in the pulse cycle. While `en` stays high without `restart`, no further check starts.
- R9: Dropping `en` abandons a check within one clock, with no pass or fail pulse.
- R10: `lim_lo`, `lim_hi` and `run_sel` are sampled when start-up completes. Changes made during measurement have no effect.
- R11: `data_in` passes through a two-stage synchronizer. Both rising and falling transitions count, and a transition is evaluated three clocks after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Check enable; a rising level starts a check |
| restart | input | 1 | Restarts the check while `en` is high |
| startup_done | input | 1 | Start-up period over; bit-check mode begins |
| tick | input | 1 | Timing-clock enable for the interval counter |
| data_in | input | 1 | Demodulated serial line (asynchronous) |
| lim_lo | input | 6 | Lower interval limit in ticks |
| lim_hi | input | 6 | Upper interval limit in ticks (up to 63) |
| run_sel | input | 2 | Required run of good intervals: 0→3, 1→6, 2/3→9 |
| pass | output | 1 | One-cycle pulse: preamble accepted |
| fail | output | 1 | One-cycle pulse: preamble rejected |
| busy | output | 1 | A check is in progress |

## Verification
Regular preambles at a mid-window spacing run with each run-length selection. They show whether the run counter stops at the selected length and whether a changed setting is wrongly picked up mid-check. A short interval after good ones and a line that goes quiet separate the lower-limit failure from the upper-limit timeout. With the tick held high, spacings of lo, lo+1, hi and hi+1 clocks test each comparison at its exact boundary. Noise during start-up, a dropped enable and a held enable after a result confirm that only the intended events start, evaluate or end a check.

// File: rtl/preamble_check_pkg.sv
// Shared types and helpers for the preamble edge-interval checker.
package preamble_check_pkg;

    localparam int RUN_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STARTUP = 2'd1,
        ST_ARMED   = 2'd2,
        ST_MEASURE = 2'd3
    } chk_state_t;

    // Map the run selection to the number of good intervals required.
    function automatic logic [RUN_W-1:0] run_len(input logic [1:0] sel);
        case (sel)
            2'd0:    run_len = RUN_W'(3);
            2'd1:    run_len = RUN_W'(6);
            default: run_len = RUN_W'(9);
        endcase
    endfunction

endpackage

// File: rtl/pc_edge_sync.sv
// Synchronizes the asynchronous data line through STAGES flops and flags
// any level change (rising or falling) seen at the synchronizer output.
// Assumes STAGES >= 2. The flag is combinational from registered state.
module pc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic edge_det
);

    logic [STAGES:0] sh;

    // First stage captures the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= data_in;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            // Each later stage delays the previous one by a clock.
            always_ff @(posedge clk) begin
                if (!rst_n) sh[g] <= 1'b0;
                else        sh[g] <= sh[g-1];
            end
        end
    endgenerate

    assign edge_det = sh[STAGES] ^ sh[STAGES-1];

endmodule

// File: rtl/pc_interval_timer.sv
// Counts timing ticks since the last transition. It clears on request and
// saturates at the limit, so it never wraps inside one interval.
module pc_interval_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             at_limit
);

    assign at_limit = (cnt >= limit);

    // Clear has priority; otherwise count ticks until the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (clear)                   cnt <= '0;
        else if (advance && cnt < limit)  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pc_ctrl.sv
// Sequencer: idle, start-up wait, armed for the first transition, then
// measuring. It latches the settings at the end of start-up, judges each
// interval and emits one-cycle pass/fail pulses before returning to idle.
module pc_ctrl
    import preamble_check_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             startup_done,
    input  logic             edge_det,
    input  logic             at_limit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       run_sel,
    output logic [CNT_W-1:0] lo_q,
    output logic [CNT_W-1:0] hi_q,
    output logic             meas,
    output logic             busy,
    output logic             pass,
    output logic             fail
);

    chk_state_t       state;
    logic             en_q;
    logic [RUN_W-1:0] good;
    logic [RUN_W-1:0] target;

    assign busy = (state != ST_IDLE);
    assign meas = (state == ST_MEASURE);

    // State, settings, run count and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            en_q   <= 1'b0;
            good   <= '0;
            target <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pass   <= 1'b0;
            fail   <= 1'b0;
        end else begin
            en_q <= en;
            pass <= 1'b0;
            fail <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else if (!en_q || restart) begin
                state <= ST_STARTUP;
            end else begin
                case (state)
                    ST_STARTUP: if (startup_done) begin
                        lo_q   <= lim_lo;
                        hi_q   <= lim_hi;
                        target <= run_len(run_sel);
                        state  <= ST_ARMED;
                    end
                    ST_ARMED: if (edge_det) begin
                        good  <= '0;
                        state <= ST_MEASURE;
                    end
                    ST_MEASURE: begin
                        if (at_limit) begin
                            fail  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (edge_det) begin
                            if (cnt < lo_q) begin
                                fail  <= 1'b1;
                                state <= ST_IDLE;
                            end else if ((good + 1'b1) == target) begin
                                pass  <= 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                good <= good + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/preamble_check.sv
// Top of the preamble edge-interval checker. Wires the synchronizer, the
// saturating interval timer and the sequencer together. The timer is held
// at zero outside measurement and restarts on every transition.
module preamble_check
    import preamble_check_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic             startup_done,
    input  logic             tick,
    input  logic             data_in,
    input  logic [CNT_W-1:0] lim_lo,
    input  logic [CNT_W-1:0] lim_hi,
    input  logic [1:0]       run_sel,
    output logic             pass,
    output logic             fail,
    output logic             busy
);

    logic             edge_det;
    logic             at_limit;
    logic             meas;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] hi_q;

    pc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .edge_det (edge_det)
    );

    pc_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!meas || edge_det),
        .advance  (tick),
        .limit    (hi_q),
        .cnt      (cnt),
        .at_limit (at_limit)
    );

    pc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .restart      (restart),
        .startup_done (startup_done),
        .edge_det     (edge_det),
        .at_limit     (at_limit),
        .cnt          (cnt),
        .lim_lo       (lim_lo),
        .lim_hi       (lim_hi),
        .run_sel      (run_sel),
        .lo_q         (lo_q),
        .hi_q         (hi_q),
        .meas         (meas),
        .busy         (busy),
        .pass         (pass),
        .fail         (fail)
    );

endmodule

// File: rtl/preamble_check_sva.sv
// Property checker for preamble_check, attached by bind below. It watches
// the result pulses, busy, the enable and the held settings and timer.
module preamble_check_sva #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             pass,
    input logic             fail,
    input logic             busy,
    input logic             meas,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lo_q,
    input logic [CNT_W-1:0] hi_q
);

    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    p_pulse_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pass || fail) |-> !busy);

    p_pass_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> !pass);

    p_fail_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && !pass && !fail));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= hi_q);

    p_hold_limits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (meas && $past(meas)) |-> ($stable(lo_q) && $stable(hi_q)));

    p_pass_from_check_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> $past(meas));

endmodule

bind preamble_check preamble_check_sva #(.CNT_W(CNT_W)) i_sva (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .pass  (pass),
    .fail  (fail),
    .busy  (busy),
    .meas  (meas),
    .cnt   (cnt),
    .lo_q  (lo_q),
    .hi_q  (hi_q)
);

// File: tb/test_preamble_check.sv
// Bench for preamble_check: a behavioural model updated on each rising edge
// is compared with the outputs on every falling edge, plus directed counts.
module test_preamble_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       restart = 1'b0;
    logic       startup_done = 1'b0;
    logic       tick = 1'b0;
    logic       data_in = 1'b0;
    logic [5:0] lim_lo = 6'd14;
    logic [5:0] lim_hi = 6'd24;
    logic [1:0] run_sel = 2'd0;
    logic       pass, fail, busy;

    int checks = 0;
    int failures = 0;
    int pass_seen = 0;
    int fail_seen = 0;
    int tick_div = 0;
    bit fast_tick = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    preamble_check i_preamble_check (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
        .startup_done(startup_done), .tick(tick), .data_in(data_in),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .run_sel(run_sel),
        .pass(pass), .fail(fail), .busy(busy)
    );

    // Reference model state
    bit dq[$] = '{0, 0, 0};
    int m_state = 0;   // 0 idle, 1 start-up, 2 armed, 3 measuring
    int m_cnt = 0, m_good = 0, m_lo = 0, m_hi = 0, m_target = 0;
    bit m_en_prev = 0, m_pass = 0, m_fail = 0;

    function automatic int need(input logic [1:0] s);
        return (s == 2'd0) ? 3 : (s == 2'd1) ? 6 : 9;
    endfunction

    always @(posedge clk) begin
        bit e;
        if (!rst_n) begin
            dq = '{0, 0, 0};
            m_state = 0; m_cnt = 0; m_good = 0; m_lo = 0; m_hi = 0;
            m_target = 0; m_en_prev = 0; m_pass = 0; m_fail = 0;
        end else begin
            e = (dq[1] != dq[2]);
            dq.push_front(data_in);
            void'(dq.pop_back());
            m_pass = 0; m_fail = 0;
            if (!en) m_state = 0;
            else if (!m_en_prev || restart) m_state = 1;
            else if (m_state == 1) begin
                if (startup_done) begin
                    m_lo = lim_lo; m_hi = lim_hi; m_target = need(run_sel);
                    m_state = 2;
                end
            end else if (m_state == 2) begin
                if (e) begin m_state = 3; m_cnt = 0; m_good = 0; end
            end else if (m_state == 3) begin
                if (m_cnt >= m_hi) begin m_fail = 1; m_state = 0; end
                else if (e) begin
                    if (m_cnt < m_lo) begin m_fail = 1; m_state = 0; end
                    else begin
                        m_good++;
                        if (m_good == m_target) begin m_pass = 1; m_state = 0; end
                    end
                    m_cnt = 0;
                end else if (tick) m_cnt++;
            end
            m_en_prev = en;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison and pulse counting, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk({cur_req, " pass"}, pass, m_pass);
            chk({cur_req, " fail"}, fail, m_fail);
            chk({cur_req, " busy"}, busy, (m_state != 0));
            if (pass) pass_seen++;
            if (fail) fail_seen++;
        end
        tick_div++;
        tick = fast_tick ? 1'b1 : ((tick_div % 4) == 0);
    end

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggles(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            clocks(period);
            data_in = ~data_in;
        end
    endtask

    // Fresh check: drop enable, set up, raise enable, noise, then start-up done.
    task automatic begin_check(input logic [1:0] sel, input int lo, input int hi);
        @(negedge clk);
        en = 0; startup_done = 0;
        clocks(2);
        run_sel = sel; lim_lo = 6'(lo); lim_hi = 6'(hi);
        en = 1;
        toggles(3, 3);          // R2: noise while start-up is pending
        clocks(8);
        startup_done = 1;
        clocks(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0, f0;
        clocks(4);
        cur_req = "R1";
        chk("R1 reset busy", busy, 0);
        chk("R1 reset pass", pass, 0);
        chk("R1 reset fail", fail, 0);
        @(negedge clk); rst_n = 1;
        clocks(3);

        // R7 / R3 / R2: run of 3, noise during start-up ignored
        cur_req = "R7";
        p0 = pass_seen; f0 = fail_seen;
        begin_check(2'd0, 14, 24);
        chk("R2 busy after start", busy, 1);
        toggles(3, 76);
        clocks(10);
        chk("R3 first edge only arms, no result after 3 edges", pass_seen - p0, 0);
        toggles(1, 76);
        clocks(10);
        chk("R7 run of 3 passes", pass_seen - p0, 1);
        chk("R2 noise ignored, no fail", fail_seen - f0, 0);
        cur_req = "R8";
        toggles(4, 76);
        clocks(10);
        chk("R8 held enable starts nothing", busy, 0);
        chk("R8 no further pass", pass_seen - p0, 1);

        // R10 with restart: run of 6, settings changed mid-check
        cur_req = "R10";
        run_sel = 2'd1;
        @(negedge clk); restart = 1;
        @(negedge clk); restart = 0;
        chk("R2 restart starts check", busy, 1);
        clocks(4);
        p0 = pass_seen; f0 = fail_seen;
        toggles(2, 76);
        lim_lo = 6'd40; run_sel = 2'd0; lim_hi = 6'd12;
        toggles(2, 76);
        clocks(10);
        chk("R10 run_sel change ignored", pass_seen - p0, 0);
        toggles(3, 76);
        clocks(10);
        chk("R10 pass after 6 with held limits", pass_seen - p0, 1);
        chk("R10 no fail", fail_seen - f0, 0);

        // R7: run of 9 via selections 2 and 3
        cur_req = "R7";
        for (int s = 2; s <= 3; s++) begin
            begin_check(2'(s), 14, 24);
            p0 = pass_seen;
            toggles(9, 76);
            clocks(10);
            chk("R7 no pass after 8 intervals", pass_seen - p0, 0);
            toggles(1, 76);
            clocks(10);
            chk("R7 pass after 9 intervals", pass_seen - p0, 1);
        end

        // R5: short interval after good ones
        cur_req = "R5";
        begin_check(2'd0, 14, 24);
        f0 = fail_seen; p0 = pass_seen;
        toggles(2, 76);
        toggles(1, 32);
        clocks(10);
        chk("R5 short interval fails", fail_seen - f0, 1);
        chk("R5 no pass", pass_seen - p0, 0);

        // R6: line goes quiet
        cur_req = "R6";
        begin_check(2'd0, 14, 24);
        f0 = fail_seen;
        toggles(2, 76);
        clocks(60);
        chk("R6 no timeout before limit", fail_seen - f0, 0);
        clocks(140);
        chk("R6 timeout without edge", fail_seen - f0, 1);

        // R9: enable dropped mid-check
        cur_req = "R9";
        begin_check(2'd0, 14, 24);
        f0 = fail_seen; p0 = pass_seen;
        toggles(2, 76);
        en = 0;
        clocks(200);
        chk("R9 abort leaves idle", busy, 0);
        chk("R9 abort gives no pulse", (fail_seen - f0) + (pass_seen - p0), 0);

        // R4 / R11: exact boundaries with tick every clock
        cur_req = "R4";
        fast_tick = 1;
        begin
            int per [4] = '{15, 14, 24, 25};
            int exp_pass [4] = '{1, 0, 1, 0};
            for (int k = 0; k < 4; k++) begin
                begin_check(2'd0, 14, 24);
                p0 = pass_seen; f0 = fail_seen;
                toggles(4, per[k]);
                clocks(40);
                chk($sformatf("R4 spacing %0d pass", per[k]), pass_seen - p0, exp_pass[k]);
                chk($sformatf("R4 spacing %0d fail", per[k]), fail_seen - f0, 1 - exp_pass[k]);
            end
        end
        fast_tick = 0;
        cur_req = "R11";
        clocks(5);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule